// File: doc/BRIEF.md
# MDIO Management Master

This block is a management master for PHY devices. A host programs it through four 32-bit registers on a simple word-addressed bus. The block then produces the management clock (MDC) and drives or samples the serial management data line (MDIO), so that the host can reach registers inside one or more PHYs. Two frame formats are available. The short format takes a 5-bit register number. The extended format first sends an address frame and then a separate write or read frame, with a 5-bit device number. A configuration bit chooses between the two formats.

A transaction is launched by a register write. A write to the data register sends a write frame. A write to the control register with its command bit set sends a read frame. In extended mode, a write to the address register sends an address frame. While a frame is in progress, a busy flag reads as 1 and every register write is dropped. After a read, the captured word can be read from the data register. If the PHY does not pull the line low in the second turnaround bit, an error flag is set.

The bus pin is split into an output, an output enable and an input. The line is expected to have a pull-up, so an undriven line reads as 1.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the word at offset 0 reads 0x0000_0400: busy, error and extended mode are 0, and the divide field in bits 15:8 holds 4. The words at offsets 1 and 2 read 0. `mdc` and `mdio_oe` are low.
- R2: While a frame runs, MDC has a period of 2×(divide field + 1) system clocks. MDC stays low while idle.
- R3: `mdio_o` changes only when MDC falls or when a frame starts, never when MDC rises. The input is sampled on MDC rising edges.
- R4: A frame begins with 32 ones, unless bit 10 of the control word (offset 1) is set. In that case the frame starts directly with the start field.
- R5: With offset 0 bit 6 = 0 (short format), writing offset 2 sends the frame 01, 01, port, register, 10, data[15:0]. Each field is sent MSB first. The port comes from control bits 9:5 and the register from control bits 4:0.
- R6: In short format, writing offset 1 with bit 15 set sends 01, 10, port, register. The master then releases `mdio_oe` from the first turnaround bit to the end of the frame and shifts in 16 bits. The captured word reads back in offset 2 bits 15:0.
- R7: With bit 6 = 1 (extended format), writing offset 3 sends 00, 00, port, device, 10, address[15:0]. In short format, a write to offset 3 only stores the value, which reads back from offset 3, and sends no frame.
- R8: In extended format, write frames use start 00 and opcode 01, and read frames use start 00 and opcode 11.
- R9: Busy reads as 1 in offset 0 bit 0 and in offset 2 bit 31 from the cycle after a launching write until the frame ends. Busy then reads 0.
- R10: A read frame whose second turnaround bit is sampled as 1 sets offset 0 bit 1. Such a read leaves 0xFFFF in the data register when the line stays high. The flag clears when the next frame starts.
- R11: Register writes made while busy is 1 are ignored. They send no frame and change no register.
- R12: The control word reads back with the register or device number in bits 4:0, the port in bits 9:5 and the preamble-off flag in bit 10. All other bits read 0, including the read command bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset: 0 config/status, 1 control, 2 data, 3 address |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench drives frames in both formats, with the preamble on and off, and with divide values 0, 1 and 3. A responder tracks MDC and answers reads. Captured write and address frames are compared bit by bit against frames built from the requirements. A mismatch there separates a wrong start or opcode field from a wrong field order. Reads are tried with a responding PHY and with a silent PHY, which tells correct capture apart from the error path and its clearing. A burst of writes issued while busy shows whether the busy lock covers every register.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int TA_POS     = 14;   // first turnaround bit inside a frame
  localparam int DATA_POS   = 16;   // first data bit inside a frame

  localparam logic [1:0] OFS_CFG  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_ADDR = 2'd3;

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_e;

  typedef struct packed {
    logic                 ext_fmt;
    logic                 no_pre;
    frame_kind_e          kind;
    logic [4:0]           port;
    logic [4:0]           dev;
    logic [DATA_BITS-1:0] payload;
  } launch_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(launch_t l);
    logic [1:0] st;
    logic [1:0] op;
    logic [1:0] ta;
    st = l.ext_fmt ? 2'b00 : 2'b01;
    case (l.kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = l.ext_fmt ? 2'b11 : 2'b10;
    endcase
    ta = (l.kind == FK_READ) ? 2'b11 : 2'b10;
    return {st, op, l.port, l.dev, ta, l.payload};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = run && (cnt_q == half_div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  launch_t              cmd,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_err,
  output logic                 rd_valid,
  output logic [DATA_BITS-1:0] rd_data
);

  localparam int PRE_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_LEN - 1);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_POS);

  logic [FRAME_BITS-1:0] frame_w;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic [PRE_W-1:0]      pre_q;
  logic                  in_pre_q;
  logic                  is_rd_q;

  assign frame_w = build_frame(cmd);
  assign idx_nx  = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_err   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      shreg_q  <= '0;
      idx_q    <= '0;
      pre_q    <= '0;
      in_pre_q <= 1'b0;
      is_rd_q  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (!active) begin
        if (start) begin
          active   <= 1'b1;
          shreg_q  <= frame_w;
          idx_q    <= '0;
          pre_q    <= PRE_LAST;
          in_pre_q <= !cmd.no_pre;
          is_rd_q  <= (cmd.kind == FK_READ);
          mdio_o   <= cmd.no_pre ? frame_w[FRAME_BITS-1] : 1'b1;
          mdio_oe  <= 1'b1;
          rd_err   <= 1'b0;
        end
      end else begin
        // capture on the rising edge of the management clock
        if (rise_tick && !in_pre_q && is_rd_q) begin
          if (idx_q == IDX_TA2) rd_err <= mdio_i;
          if (idx_q >= IDX_DAT) rd_data <= {rd_data[DATA_BITS-2:0], mdio_i};
        end
        // launch the next bit on the falling edge
        if (fall_tick) begin
          if (in_pre_q) begin
            if (pre_q == '0) begin
              in_pre_q <= 1'b0;
              mdio_o   <= shreg_q[FRAME_BITS-1];
            end else begin
              pre_q <= pre_q - 1'b1;
            end
          end else if (idx_q == IDX_LAST) begin
            active   <= 1'b0;
            mdio_oe  <= 1'b0;
            mdio_o   <= 1'b1;
            rd_valid <= is_rd_q;
          end else begin
            idx_q   <= idx_nx;
            shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
            mdio_o  <= shreg_q[FRAME_BITS-2];
            mdio_oe <= !(is_rd_q && (idx_nx >= IDX_TA1));
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           bus_addr,
  input  logic                 bus_wr_en,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd_en,
  output logic [31:0]          bus_rdata,
  input  logic                 busy,
  input  logic                 rd_err,
  input  logic                 rd_valid,
  input  logic [DATA_BITS-1:0] rd_data,
  output logic                 start,
  output launch_t              cmd,
  output logic [DIV_W-1:0]     half_div
);

  logic [DIV_W-1:0]     div_q;
  logic                 ext_q;
  logic [4:0]           dev_q;
  logic [4:0]           port_q;
  logic                 nopre_q;
  logic [DATA_BITS-1:0] data_q;
  logic [DATA_BITS-1:0] addr_q;

  logic wr_ok, wr_cfg, wr_ctrl, wr_data, wr_addr;
  logic unused_wbits;

  assign wr_ok   = bus_wr_en && !busy;
  assign wr_cfg  = wr_ok && (bus_addr == OFS_CFG);
  assign wr_ctrl = wr_ok && (bus_addr == OFS_CTRL);
  assign wr_data = wr_ok && (bus_addr == OFS_DATA);
  assign wr_addr = wr_ok && (bus_addr == OFS_ADDR);

  assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[14:11], bus_wdata[7], bus_wdata[5:0]};

  assign start = (wr_ctrl && bus_wdata[15]) || wr_data || (wr_addr && ext_q);
  assign half_div = div_q;

  always_comb begin
    cmd.ext_fmt = ext_q;
    cmd.no_pre  = wr_ctrl ? bus_wdata[10]  : nopre_q;
    cmd.port    = wr_ctrl ? bus_wdata[9:5] : port_q;
    cmd.dev     = wr_ctrl ? bus_wdata[4:0] : dev_q;
    cmd.kind    = wr_data ? FK_WRITE : (wr_addr ? FK_ADDR : FK_READ);
    cmd.payload = bus_wdata[DATA_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(DIV_RESET);
      ext_q   <= 1'b0;
      dev_q   <= '0;
      port_q  <= '0;
      nopre_q <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (wr_cfg) begin
        div_q <= bus_wdata[8 +: DIV_W];
        ext_q <= bus_wdata[6];
      end
      if (wr_ctrl) begin
        dev_q   <= bus_wdata[4:0];
        port_q  <= bus_wdata[9:5];
        nopre_q <= bus_wdata[10];
      end
      if (wr_data) data_q <= bus_wdata[DATA_BITS-1:0];
      if (wr_addr) addr_q <= bus_wdata[DATA_BITS-1:0];
      if (rd_valid) data_q <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      bus_rdata <= '0;
      case (bus_addr)
        OFS_CFG: begin
          bus_rdata[8 +: DIV_W] <= div_q;
          bus_rdata[6]          <= ext_q;
          bus_rdata[1]          <= rd_err;
          bus_rdata[0]          <= busy;
        end
        OFS_CTRL: bus_rdata[10:0] <= {nopre_q, port_q, dev_q};
        OFS_DATA: begin
          bus_rdata[31]            <= busy;
          bus_rdata[DATA_BITS-1:0] <= data_q;
        end
        default:  bus_rdata[DATA_BITS-1:0] <= addr_q;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr_en,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd_en,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic                 busy;
  logic                 rd_err;
  logic                 rd_valid;
  logic [DATA_BITS-1:0] rd_data;
  logic                 start;
  launch_t              cmd;
  logic [DIV_W-1:0]     half_div;
  logic                 rise_tick;
  logic                 fall_tick;

  mdio_reg_bank #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .rd_err    (rd_err),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .start     (start),
    .cmd       (cmd),
    .half_div  (half_div)
  );

  mdio_mdc_gen #(
    .DIV_W (DIV_W)
  ) i_clkgen (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .half_div  (half_div),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine #(
    .PRE_LEN (PRE_LEN)
  ) i_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd       (cmd),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .active    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_err    (rd_err),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst,
  input logic bus_wr_en,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rd_err
);

  // R2: no management clock activity outside a frame
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R3: the data output never moves on a rising management clock
  a_r3_out_stable_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $stable(mdio_o));

  // R6: the line is never driven outside a frame
  a_r6_oe_only_in_frame: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R9: a frame only begins after a register write
  a_r9_busy_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr_en));

  // R10: the error flag moves only at a frame start or inside a frame
  a_r10_err_moves_in_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_err) |-> busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr_en (bus_wr_en),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_err    (rd_err)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/100ps
module test_mdio_mgmt_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.DIV_RESET(4), .PRE_LEN(32)) i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder and line model (pull-up)
  logic        phy_en = 1'b0, phy_drv = 1'b0, phy_bit = 1'b1;
  logic [15:0] phy_word = '0;
  int          pre_exp = 32;
  assign mdio_i = phy_drv ? phy_bit : (mdio_oe ? mdio_o : 1'b1);

  logic [63:0] cap = '0;
  int ncap = 0, nframes = 0, cyc = 0, last_rise = -1, mdc_period = 0, r3_viol = 0;
  logic p_mdc = 1'b0, p_oe = 1'b0, p_o = 1'b1;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mdio_oe && !p_oe) begin ncap = 0; nframes++; phy_drv = 1'b0; end
    if (mdc && !p_mdc) begin
      cap = {cap[62:0], mdio_i};
      ncap++;
      if (last_rise >= 0) mdc_period = cyc - last_rise;
      last_rise = cyc;
      if (mdio_o != p_o) r3_viol++;
    end
    if (!mdc && p_mdc) begin
      if (phy_en && ncap == pre_exp + 15 && cap[12]) begin phy_drv = 1'b1; phy_bit = 1'b0; end
      else if (phy_drv && ncap >= pre_exp + 16 && ncap <= pre_exp + 31) phy_bit = phy_word[pre_exp + 31 - ncap];
      else if (ncap >= pre_exp + 32) phy_drv = 1'b0;
    end
    p_mdc = mdc; p_oe = mdio_oe; p_o = mdio_o;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk); bus_rd_en = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, s);
      if (!s[0]) return;
    end
    chk({tag, " busy never cleared"}, 1, 0);
  endtask

  function automatic logic [31:0] ef(bit ext, bit [1:0] op, bit [4:0] pa, bit [4:0] da, bit [15:0] d);
    return {(ext ? 2'b00 : 2'b01), op, pa, da, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 cfg word", v, 32'h0000_0400);
    rd(2'd1, v); chk("R1 ctrl word", v, 0);
    rd(2'd2, v); chk("R1 data word", v, 0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", mdio_oe, 0);
  endtask

  task automatic t_short_write();
    logic [31:0] v;
    int n0;
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, (32'h11 << 5) | 32'h0A);
    pre_exp = 32; n0 = nframes;
    wr(2'd2, 32'h0000_BEEF);
    rd(2'd0, v); chk("R9 busy in cfg", v[0], 1);
    rd(2'd2, v); chk("R9 busy in data", v[31], 1);
    wait_idle("R5");
    rd(2'd2, v); chk("R9 busy cleared in data", v[31], 0);
    chk("R4 bit count with preamble", ncap, 64);
    chk("R4 preamble ones", cap[63:32], 32'hFFFF_FFFF);
    chk("R5 write frame", cap[31:0], ef(0, 2'b01, 5'h11, 5'h0A, 16'hBEEF));
    chk("R2 period div1", mdc_period, 4);
    chk("R5 one frame", nframes - n0, 1);
  endtask

  task automatic t_short_read();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0300);
    pre_exp = 0; phy_en = 1'b1; phy_word = 16'h5A3C;
    wr(2'd1, (32'h1 << 15) | (32'h1 << 10) | (32'h03 << 5) | 32'h1F);
    wait_idle("R6");
    chk("R4 bit count without preamble", ncap, 32);
    chk("R6 read header", cap[31:18], ef(0, 2'b10, 5'h03, 5'h1F, 0) >> 18);
    rd(2'd2, v); chk("R6 captured word", v, 32'h0000_5A3C);
    rd(2'd0, v); chk("R10 no error", v[1], 0);
    chk("R2 period div3", mdc_period, 8);
    rd(2'd1, v); chk("R12 ctrl readback drops cmd", v, (32'h1 << 10) | (32'h03 << 5) | 32'h1F);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0140);
    wr(2'd1, (32'h07 << 5) | 32'h01);
    pre_exp = 32;
    wr(2'd3, 32'h0000_1234);
    wait_idle("R7");
    chk("R7 address frame", cap[31:0], ef(1, 2'b00, 5'h07, 5'h01, 16'h1234));
    wr(2'd2, 32'h0000_CAFE);
    wait_idle("R8");
    chk("R8 ext write frame", cap[31:0], ef(1, 2'b01, 5'h07, 5'h01, 16'hCAFE));
    phy_en = 1'b1; phy_word = 16'h0F0F;
    wr(2'd1, (32'h1 << 15) | (32'h07 << 5) | 32'h01);
    wait_idle("R8");
    chk("R8 ext read header", cap[31:18], ef(1, 2'b11, 5'h07, 5'h01, 0) >> 18);
    rd(2'd2, v); chk("R8 ext read word", v, 32'h0000_0F0F);
  endtask

  task automatic t_short_addr();
    logic [31:0] v;
    int n0;
    wr(2'd0, 32'h0000_0100);
    n0 = nframes;
    wr(2'd3, 32'h0000_5555);
    repeat (50) @(negedge clk);
    chk("R7 no frame in short format", nframes - n0, 0);
    rd(2'd3, v); chk("R7 address stored", v, 32'h0000_5555);
  endtask

  task automatic t_read_err();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0000);
    pre_exp = 32; phy_en = 1'b0;
    wr(2'd1, (32'h1 << 15) | (32'h02 << 5) | 32'h03);
    wait_idle("R10");
    rd(2'd0, v); chk("R10 error set", v[1], 1);
    rd(2'd2, v); chk("R10 all ones", v, 32'h0000_FFFF);
    chk("R2 period div0", mdc_period, 2);
    phy_en = 1'b1; phy_word = 16'h0001;
    wr(2'd1, (32'h1 << 15) | (32'h02 << 5) | 32'h03);
    rd(2'd0, v); chk("R10 error cleared at launch", v[1:0], 2'b01);
    wait_idle("R10");
    rd(2'd2, v); chk("R10 good read after error", v, 32'h0000_0001);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int n0;
    wr(2'd0, 32'h0000_0300);
    wr(2'd1, (32'h01 << 5) | 32'h02);
    pre_exp = 32; n0 = nframes;
    wr(2'd2, 32'h0000_1111);
    wr(2'd1, 32'h0000_83FF);
    wr(2'd2, 32'h0000_2222);
    wr(2'd3, 32'h0000_7777);
    wr(2'd0, 32'h0000_FF40);
    wait_idle("R11");
    chk("R11 single frame", nframes - n0, 1);
    chk("R5 payload kept", cap[15:0], 16'h1111);
    rd(2'd1, v); chk("R11 ctrl unchanged", v, (32'h01 << 5) | 32'h02);
    rd(2'd2, v); chk("R11 data unchanged", v, 32'h0000_1111);
    rd(2'd0, v); chk("R11 cfg unchanged", v, 32'h0000_0300);
    rd(2'd3, v); chk("R11 addr unchanged", v, 32'h0000_5555);
  endtask

  task automatic t_ctrl_readback();
    logic [31:0] v;
    wr(2'd1, 32'hABCD_4FFF);
    rd(2'd1, v); chk("R12 reserved bits read zero", v, 32'h0000_07FF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_short_write();
    t_short_read();
    t_ext();
    t_short_addr();
    t_read_err();
    t_busy_ignore();
    t_ctrl_readback();
    chk("R3 no change on rising mdc", r3_viol, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule